// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that software must service at the right moment, not just often enough. A down-counter runs on its own watchdog clock, separate from the system clock. Software services it by writing a two-byte key on the system side. A key that lands while the count is inside a programmable permitted band reloads the counter. A key that lands outside that band is an error. If the counter runs down through zero, that is also an error. Either error raises the response chosen on the configuration pins: a timed reset request, a non-maskable interrupt request or an ordinary interrupt request.

The counter stays parked at full scale until it is started. It starts on its own once reset is released if the auto-start pin is high. Otherwise the first correctly keyed service starts it, and that first service is not checked against the band. The error flags are sticky, live in the watchdog domain and are copied into the system domain for reading. A write on the clear strobe drops them together with the pending interrupt requests. The current count is brought out in the watchdog clock domain.

Top module: `wdt_window`

## Requirements
- R1: Once started, the count drops by exactly one every DIV watchdog clocks (the default count width is 14 bits, full scale 2^W-1).
- R2: Before it is started the count holds at full scale. It starts when auto_start is high after reset, or on the first correctly keyed service, which is not checked against the band.
- R3: A service key is a write of 0x00 followed, on the next write, by a write of 0xFF. Any other write sequence is ignored and does not reload or start the counter.
- R4: With the block started, a keyed service is valid when hi >= count > lo, where hi = (s+1)*2^W/4 - 1 for band-start code s and lo = e*2^W/4 for band-end code e. Codes 0..3 mean 25/50/75/100 % for the start and 0/25/50/75 % for the end. A valid service reloads the count to full scale.
- R5: A keyed service outside the band sets the service-error flag, raises the selected response and reloads the count to full scale.
- R6: A tick that finds the count at zero sets the underflow flag, raises the selected response and reloads the count to full scale.
- R7: Response code 00 or 11 produces a reset request pulse lasting exactly RST_CYC watchdog clocks. Code 01 sets the non-maskable request and code 10 sets the ordinary interrupt request. Each request holds until cleared.
- R8: The error flags and the interrupt requests stay set until a write on clr_wr, and are unaffected by any other activity.
- R9: The two error flags reach the system clock domain through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System domain reset, active low |
| wd_clk | input | 1 | Dedicated watchdog clock |
| wd_rst_n | input | 1 | Watchdog domain reset, active low |
| ref_wr | input | 1 | Service key write strobe (system domain) |
| ref_data | input | 8 | Service key byte |
| clr_wr | input | 1 | Status clear strobe (system domain) |
| auto_start | input | 1 | Start counting directly after reset |
| resp_sel | input | 2 | Error response: 00 reset, 01 NMI, 10 IRQ, 11 reset |
| win_start | input | 2 | Upper band edge code |
| win_end | input | 2 | Lower band edge code |
| rst_req | output | 1 | Reset request pulse (watchdog domain) |
| nmi_req | output | 1 | Non-maskable interrupt request (watchdog domain) |
| irq_req | output | 1 | Interrupt request (watchdog domain) |
| uf_flag | output | 1 | Underflow flag, system domain |
| rerr_flag | output | 1 | Service-error flag, system domain |
| count | output | CNT_W | Current count, watchdog domain |

## Verification
The hardest situation to create from the ports is a service key that lands at a known count. The key crosses from the system clock into the unrelated watchdog clock, so its arrival varies by a few ticks. The stimulus therefore picks random band codes and random target counts, rejecting any target within sixteen ticks of either band edge. It waits until the count output shows the target and then sends the key, so that the expected verdict computed in the bench is unambiguous. The exact edge comparison at the moment of arrival is covered by the bound checker, which recomputes the band from the edge codes by bit concatenation.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    RESP_RST  = 2'b00,
    RESP_NMI  = 2'b01,
    RESP_IRQ  = 2'b10,
    RESP_RST2 = 2'b11
  } resp_e;

  localparam logic [7:0] KEY_FIRST  = 8'h00;
  localparam logic [7:0] KEY_SECOND = 8'hFF;

  // Upper band edge: (code+1)/4 of the range, minus one.
  function automatic int unsigned win_hi(input int unsigned w, input logic [1:0] code);
    int unsigned c;
    c = {30'd0, code};
    return ((c + 1) * (32'd1 << w)) / 4 - 1;
  endfunction

  // Lower band edge (exclusive): code/4 of the range.
  function automatic int unsigned win_lo(input int unsigned w, input logic [1:0] code);
    int unsigned c;
    c = {30'd0, code};
    return (c * (32'd1 << w)) / 4;
  endfunction

  function automatic logic in_win(input int unsigned w, input logic [1:0] s,
                                  input logic [1:0] e, input int unsigned cnt);
    return (cnt <= win_hi(w, s)) && (cnt > win_lo(w, e));
  endfunction

endpackage

// File: rtl/wdt_pulse_xing.sv
module wdt_pulse_xing (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic       tog_q;
  logic [2:0] sync_q;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tog_q <= 1'b0;
    else            tog_q <= tog_q ^ src_pulse;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) sync_q <= '0;
    else            sync_q <= {sync_q[1:0], tog_q};
  end

  assign dst_pulse = sync_q[2] ^ sync_q[1];
endmodule

// File: rtl/wdt_flag_sync.sv
module wdt_flag_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] data,
  output logic       key_ok
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  armed_q <= 1'b0;
    else if (wr) armed_q <= (data == KEY_FIRST);
  end

  assign key_ok = wr && armed_q && (data == KEY_SECOND);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int DIV     = 4,
  parameter int RST_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             clr_pulse,
  input  logic             auto_start,
  input  logic [1:0]       resp_sel,
  input  logic [1:0]       win_start,
  input  logic [1:0]       win_end,
  output logic [CNT_W-1:0] count,
  output logic             uf_flag,
  output logic             re_flag,
  output logic             rst_req,
  output logic             nmi_req,
  output logic             irq_req,
  output logic             started,
  output logic             tick,
  output logic             uf_evt,
  output logic             ref_ok,
  output logic             ref_bad
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam int PS_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             started_q;
  logic             in_band;
  logic             err_evt;
  logic             reload;
  logic             uf_q, re_q, nmi_q, irq_q;
  logic [RC_W-1:0]  rst_cnt_q;
  resp_e            mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       started_q <= 1'b0;
    else if (auto_start || ref_pulse) started_q <= 1'b1;
  end

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = started_q;
    end else begin : g_div
      logic [PS_W-1:0] ps_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         ps_q <= '0;
        else if (!started_q)                ps_q <= '0;
        else if (ps_q == PS_W'(DIV - 1))    ps_q <= '0;
        else                                ps_q <= ps_q + 1'b1;
      end
      assign tick = started_q && (ps_q == PS_W'(DIV - 1));
    end
  endgenerate

  assign in_band = in_win(CNT_W, win_start, win_end, 32'(cnt_q));
  assign uf_evt  = tick && (cnt_q == '0);
  assign ref_ok  = ref_pulse && started_q && in_band;
  assign ref_bad = ref_pulse && started_q && !in_band;
  assign err_evt = uf_evt || ref_bad;
  assign reload  = err_evt || ref_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= CMAX;
    else if (!started_q || reload)   cnt_q <= CMAX;
    else if (tick)                   cnt_q <= cnt_q - 1'b1;
  end

  assign mode = resp_e'(resp_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q  <= 1'b0;
      re_q  <= 1'b0;
      nmi_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (uf_evt)                          uf_q  <= 1'b1;
      else if (clr_pulse)                  uf_q  <= 1'b0;
      if (ref_bad)                         re_q  <= 1'b1;
      else if (clr_pulse)                  re_q  <= 1'b0;
      if (err_evt && mode == RESP_NMI)     nmi_q <= 1'b1;
      else if (clr_pulse)                  nmi_q <= 1'b0;
      if (err_evt && mode == RESP_IRQ)     irq_q <= 1'b1;
      else if (clr_pulse)                  irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_cnt_q <= '0;
    else if (err_evt && (mode == RESP_RST || mode == RESP_RST2))
      rst_cnt_q <= RC_W'(RST_CYC);
    else if (rst_cnt_q != '0)
      rst_cnt_q <= rst_cnt_q - 1'b1;
  end

  assign count   = cnt_q;
  assign started = started_q;
  assign uf_flag = uf_q;
  assign re_flag = re_q;
  assign nmi_req = nmi_q;
  assign irq_req = irq_q;
  assign rst_req = (rst_cnt_q != '0);
endmodule

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int CNT_W   = 14,
  parameter int DIV     = 4,
  parameter int RST_CYC = 16
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             wd_clk,
  input  logic             wd_rst_n,
  input  logic             ref_wr,
  input  logic [7:0]       ref_data,
  input  logic             clr_wr,
  input  logic             auto_start,
  input  logic [1:0]       resp_sel,
  input  logic [1:0]       win_start,
  input  logic [1:0]       win_end,
  output logic             rst_req,
  output logic             nmi_req,
  output logic             irq_req,
  output logic             uf_flag,
  output logic             rerr_flag,
  output logic [CNT_W-1:0] count
);
  logic key_ok_w;
  logic ref_pulse_w, clr_pulse_w;
  logic started_w, tick_w, uf_evt_w, ref_ok_w, ref_bad_w;
  logic uf_wd, re_wd;
  logic [1:0] flags_sys;

  wdt_key_seq u_key (
    .clk(sys_clk), .rst_n(sys_rst_n), .wr(ref_wr), .data(ref_data), .key_ok(key_ok_w)
  );

  wdt_pulse_xing u_ref_x (
    .src_clk(sys_clk), .src_rst_n(sys_rst_n), .src_pulse(key_ok_w),
    .dst_clk(wd_clk), .dst_rst_n(wd_rst_n), .dst_pulse(ref_pulse_w)
  );

  wdt_pulse_xing u_clr_x (
    .src_clk(sys_clk), .src_rst_n(sys_rst_n), .src_pulse(clr_wr),
    .dst_clk(wd_clk), .dst_rst_n(wd_rst_n), .dst_pulse(clr_pulse_w)
  );

  wdt_core #(.CNT_W(CNT_W), .DIV(DIV), .RST_CYC(RST_CYC)) u_core (
    .clk(wd_clk), .rst_n(wd_rst_n),
    .ref_pulse(ref_pulse_w), .clr_pulse(clr_pulse_w),
    .auto_start(auto_start), .resp_sel(resp_sel),
    .win_start(win_start), .win_end(win_end),
    .count(count), .uf_flag(uf_wd), .re_flag(re_wd),
    .rst_req(rst_req), .nmi_req(nmi_req), .irq_req(irq_req),
    .started(started_w), .tick(tick_w), .uf_evt(uf_evt_w),
    .ref_ok(ref_ok_w), .ref_bad(ref_bad_w)
  );

  wdt_flag_sync #(.W(2)) u_flag_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d({re_wd, uf_wd}), .q(flags_sys)
  );

  assign uf_flag   = flags_sys[0];
  assign rerr_flag = flags_sys[1];
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk #(
  parameter int CNT_W = 14
) (
  input logic             wd_clk,
  input logic             wd_rst_n,
  input logic             started,
  input logic             tick,
  input logic             uf_evt,
  input logic             ref_pulse,
  input logic             clr_pulse,
  input logic             ref_bad,
  input logic [CNT_W-1:0] cnt,
  input logic             uf_w,
  input logic             re_w,
  input logic             rst_req,
  input logic [1:0]       win_start,
  input logic [1:0]       win_end
);
  logic [CNT_W-1:0] hi_c, lo_c;
  logic             in_c;

  assign hi_c = {win_start, {(CNT_W-2){1'b1}}};
  assign lo_c = {win_end,   {(CNT_W-2){1'b0}}};
  assign in_c = (cnt <= hi_c) && (cnt > lo_c);

  a_r1_step_by_one: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (started && tick && cnt != '0 && !ref_pulse) |=> (cnt == $past(cnt) - 1'b1));

  a_r2_parked_full: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    !started |-> (cnt == {CNT_W{1'b1}}));

  a_r4_valid_reload: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (ref_pulse && started && in_c) |=> (cnt == {CNT_W{1'b1}}));

  a_r5_bad_sets_flag: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (ref_pulse && started && !in_c) |=> re_w);

  a_r6_zero_tick_flag: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (started && tick && cnt == '0) |=> (uf_w && cnt == {CNT_W{1'b1}}));

  a_r7_reset_from_error: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    $rose(rst_req) |-> $past(uf_evt || ref_bad));

  a_r8_uf_sticky: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (uf_w && !clr_pulse) |=> uf_w);

  a_r8_re_sticky: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (re_w && !clr_pulse) |=> re_w);
endmodule

bind wdt_window wdt_window_chk #(.CNT_W(CNT_W)) u_chk (
  .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .started(started_w), .tick(tick_w),
  .uf_evt(uf_evt_w), .ref_pulse(ref_pulse_w), .clr_pulse(clr_pulse_w),
  .ref_bad(ref_bad_w), .cnt(count), .uf_w(uf_wd), .re_w(re_wd),
  .rst_req(rst_req), .win_start(win_start), .win_end(win_end)
);

// File: tb/wdt_window_test.sv
module wdt_window_test;
  localparam int CW   = 10;
  localparam int DV   = 2;
  localparam int RC   = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic sys_clk = 0, wd_clk = 0;
  logic sys_rst_n = 0, wd_rst_n = 0;
  logic ref_wr = 0, clr_wr = 0, auto_start = 0;
  logic [7:0] ref_data = 0;
  logic [1:0] resp_sel = 2'b01, win_start = 2'b11, win_end = 2'b00;
  logic rst_req, nmi_req, irq_req, uf_flag, rerr_flag;
  logic [CW-1:0] count;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 sys_clk = ~sys_clk;
  always #15 wd_clk  = ~wd_clk;

  wdt_window #(.CNT_W(CW), .DIV(DV), .RST_CYC(RC)) uut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
    .ref_wr(ref_wr), .ref_data(ref_data), .clr_wr(clr_wr), .auto_start(auto_start),
    .resp_sel(resp_sel), .win_start(win_start), .win_end(win_end),
    .rst_req(rst_req), .nmi_req(nmi_req), .irq_req(irq_req),
    .uf_flag(uf_flag), .rerr_flag(rerr_flag), .count(count)
  );

  function automatic int exp_hi(input int s); return ((s + 1) * (CMAX + 1)) / 4 - 1; endfunction
  function automatic int exp_lo(input int e); return (e * (CMAX + 1)) / 4; endfunction
  function automatic bit near(input int a, input int b); return (a > b - 16) && (a < b + 16); endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wdw(input int n); repeat (n) @(negedge wd_clk); endtask

  task automatic wr(input logic [7:0] d);
    @(negedge sys_clk); ref_wr = 1; ref_data = d;
    @(negedge sys_clk); ref_wr = 0;
  endtask

  task automatic service(); wr(8'h00); wr(8'hFF); endtask

  task automatic clear();
    @(negedge sys_clk); clr_wr = 1;
    @(negedge sys_clk); clr_wr = 0;
    wdw(10);
  endtask

  task automatic do_reset(input logic as);
    auto_start = as; sys_rst_n = 0; wd_rst_n = 0;
    wdw(3); sys_rst_n = 1; wd_rst_n = 1;
  endtask

  task automatic wait_count(input int tgt);
    for (int k = 0; k < 6000 && int'(count) != tgt; k++) @(negedge wd_clk);
  endtask

  initial begin
    repeat (190000) @(posedge sys_clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0, c1, n, s, e, tgt, hi, lo, upper;
    bit valid, sel_nmi;
    void'($urandom(32'd20240611));
    do_reset(0);
    wdw(20);
    // Reset state
    check(int'(count) == CMAX, "R2", "parked count", count, CMAX);
    check(!uf_flag && !rerr_flag, "R8", "flags after reset", {uf_flag, rerr_flag}, 0);
    check(!rst_req && !nmi_req && !irq_req, "R7", "idle requests", {rst_req, nmi_req, irq_req}, 0);

    // Broken sequences are ignored
    wr(8'h00); wr(8'h55); wr(8'hFF); wr(8'hFF);
    wdw(20);
    check(int'(count) == CMAX, "R3", "broken key ignored", count, CMAX);

    // First keyed service starts the counter
    service();
    wdw(20);
    check(int'(count) < CMAX && int'(count) > CMAX - 20, "R2", "started by key", count, CMAX - 10);
    check(!rerr_flag, "R2", "first key unchecked", rerr_flag, 0);

    // Decrement rate
    c0 = count; wdw(2 * 50); c1 = count;
    check(c0 - c1 == 50, "R1", "ticks per 100 wd clocks", c0 - c1, 50);

    // Random band / target trials
    for (int i = 0; i < 20; i++) begin
      s = $urandom_range(3, 0); e = $urandom_range(3, 0);
      sel_nmi = $urandom_range(1, 0);
      @(negedge wd_clk);
      win_start = s[1:0]; win_end = e[1:0]; resp_sel = sel_nmi ? 2'b01 : 2'b10;
      hi = exp_hi(s); lo = exp_lo(e);
      upper = int'(count) - 30;
      for (int k = 0; k < 200; k++) begin
        tgt = $urandom_range(upper, 24);
        if (!near(tgt, hi) && !near(tgt, lo)) break;
      end
      wait_count(tgt);
      service();
      wdw(14);
      valid = (tgt <= hi) && (tgt > lo);
      check(rerr_flag == !valid, valid ? "R4" : "R5", "service verdict", rerr_flag, !valid);
      check(int'(count) >= CMAX - 20, "R4", "reload after service", count, CMAX);
      if (!valid) begin
        check(nmi_req == sel_nmi, "R7", "nmi request", nmi_req, sel_nmi);
        check(irq_req == !sel_nmi, "R7", "irq request", irq_req, !sel_nmi);
      end
      clear();
      check(!rerr_flag && !nmi_req && !irq_req, "R8", "clear drops state", {rerr_flag, nmi_req, irq_req}, 0);
    end

    // Underflow with IRQ response
    @(negedge wd_clk); resp_sel = 2'b10;
    wait_count(0);
    wdw(14);
    check(uf_flag == 1, "R6", "underflow flag", uf_flag, 1);
    check(irq_req && !nmi_req && !rst_req, "R7", "irq only", {rst_req, nmi_req, irq_req}, 1);
    check(int'(count) >= CMAX - 20, "R6", "reload after underflow", count, CMAX);
    wdw(40);
    check(uf_flag == 1 && irq_req, "R8", "sticky underflow", uf_flag, 1);
    clear();
    check(!uf_flag && !irq_req, "R9", "flag cleared in sys domain", uf_flag, 0);

    // Early service in reset mode: pulse length
    @(negedge wd_clk); win_start = 2'b00; win_end = 2'b00; resp_sel = 2'b00;
    service();
    for (int k = 0; k < 60 && !rst_req; k++) @(negedge wd_clk);
    n = 0;
    while (rst_req && n < 100) begin n++; @(negedge wd_clk); end
    check(n == RC, "R7", "reset pulse length", n, RC);
    wdw(6);
    check(rerr_flag == 1, "R5", "early service flagged", rerr_flag, 1);
    check(!nmi_req && !irq_req, "R7", "no interrupt in reset mode", {nmi_req, irq_req}, 0);

    // Auto start after reset
    do_reset(1);
    wdw(20);
    check(int'(count) < CMAX && int'(count) > CMAX - 20, "R2", "auto start", count, CMAX - 10);
    check(!uf_flag && !rerr_flag, "R9", "flags after second reset", {uf_flag, rerr_flag}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule